// File: doc/BRIEF.md
# Ping-Pong Transfer Buffer with Card Clock Stall

This block sits between the host side of a card controller (processor or DMA) and the serial engine that moves data to and from the card. It holds two equal banks of 32-bit words, called X (index 0) and Y (index 1). The bank being filled and the bank being emptied alternate. In a read transfer the card engine fills the banks and the host empties them. In a write transfer the host fills the banks and the card engine empties them. A bank is handed to the emptying side only once it holds a complete set of words. It goes back to the filling side only once every word in it has been taken out.

If the card side can make no progress, the block raises a clock-stop request toward the card engine. In a read transfer this happens when both banks are full. In a write transfer it happens when no bank is full. Two sticky status flags record these events: underrun for write transfers and overflow for read transfers. Each flag has an interrupt enable. A flag is cleared by writing a one to its bit. A live flag shows whether bank X is full during a read transfer.

The control state machine has three states:
- IDLE is entered from reset.
- A start pulse moves the machine to READ when `dir_read` is high, and to WRITE when it is low. A start pulse has this effect from any state.
- No other transition exists.

Each start pulse also empties both banks and points both sides back at bank X.

Top module: `pingpong_xfer_buf`

## Requirements
- R1: After reset the block is in IDLE. In IDLE, `card_clk_stop`, `host_ready`, `underrun`, `overflow`, `xbuf_full` and `irq` are all low.
- R2: Words leave the block in the order they entered. Bank X is filled first, and ownership of a bank changes after exactly DEPTH words have been written to it or read from it.
- R3: In READ, `card_clk_stop` is high exactly while both banks are full. It goes low in the cycle after the host takes the last word of a bank.
- R4: In READ, a card word offered while both banks are full is discarded and never reaches the host.
- R5: In WRITE, `card_clk_stop` is high exactly while no bank is full. A `card_take` while stopped moves no data.
- R6: `overflow` goes high one cycle after a READ cycle in which both banks are full. `underrun` goes high one cycle after a WRITE cycle in which no bank is full. Both flags stay high until cleared.
- R7: `xbuf_full` is high in READ while bank X holds a complete set of words. It goes low in the cycle after the last word of X is read out. It is low in WRITE.
- R8: `irq` is high when `underrun` is high with `irq_en[0]` set, or when `overflow` is high with `irq_en[1]` set.
- R9: A cycle with `stat_wr` high clears `underrun` when `stat_wdata[0]` is 1 and clears `overflow` when `stat_wdata[1]` is 1. Zero bits leave their flag unchanged.
- R10: If a set condition and a clearing write hit the same flag in the same cycle, the flag ends high.
- R11: A start pulse empties both banks and resets both pointers to the first word of X, including in the middle of a transfer.
- R12: `host_ready` is high in READ when the bank the host empties is full. It is high in WRITE when the bank the host fills still has room.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a transfer; empties the banks |
| dir_read | input | 1 | Transfer direction sampled at start: 1 read, 0 write |
| host_wr | input | 1 | Host writes a word (WRITE) |
| host_wdata | input | DW | Host write word |
| host_rd | input | 1 | Host takes a word (READ) |
| host_rdata | output | DW | Word at the head of the bank being emptied |
| host_ready | output | 1 | Host may write (WRITE) or read (READ) |
| card_valid | input | 1 | Card engine offers a word (READ) |
| card_wdata | input | DW | Word from the card |
| card_take | input | 1 | Card engine takes a word (WRITE) |
| card_rdata | output | DW | Word toward the card |
| card_clk_stop | output | 1 | Request to halt the card clock |
| stat_wr | input | 1 | Status write strobe |
| stat_wdata | input | 2 | Write-one-to-clear mask: bit 0 underrun, bit 1 overflow |
| irq_en | input | 2 | Interrupt enables: bit 0 underrun, bit 1 overflow |
| underrun | output | 1 | Sticky underrun flag |
| overflow | output | 1 | Sticky overflow flag |
| xbuf_full | output | 1 | Bank X full during READ |
| irq | output | 1 | Interrupt request |

## Verification
The clock-stop request, `host_ready`, `xbuf_full` and both data outputs are decoded from registered bank state. They take their new value in the cycle that follows the edge at which a word or a start pulse was accepted. The flags are registered one stage after their condition, so they appear one cycle after the bank state that causes them. `irq` follows the flags and enables within the same cycle. The bench changes inputs on the falling edge and samples on the next falling edge, one rising edge later. For the flags, each expected value is tied to the bank state that held during the previous vector. An enable change is sampled shortly after it is applied, with no clock edge in between.

// File: rtl/pxb_pkg.sv
package pxb_pkg;
    typedef enum logic [1:0] {
        XB_IDLE  = 2'd0,
        XB_READ  = 2'd1,
        XB_WRITE = 2'd2
    } xfer_state_t;
endpackage

// File: rtl/pxb_store.sv
module pxb_store #(
    parameter int DW    = 32,
    parameter int DEPTH = 16,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          wr_en,
    input  logic          wr_sel,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic          set_full,
    input  logic          rd_sel,
    input  logic [AW-1:0] rd_addr,
    input  logic          clr_full,
    output logic [DW-1:0] rd_data,
    output logic [1:0]    full
);
    logic [DW-1:0] word [2];

    for (genvar g = 0; g < 2; g++) begin : g_bank
        logic [DW-1:0] mem [DEPTH];
        logic          full_q;

        always_ff @(posedge clk) begin
            if (wr_en && (wr_sel == 1'(g))) begin
                mem[wr_addr] <= wr_data;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                full_q <= 1'b0;
            end else if (flush) begin
                full_q <= 1'b0;
            end else if (set_full && (wr_sel == 1'(g))) begin
                full_q <= 1'b1;
            end else if (clr_full && (rd_sel == 1'(g))) begin
                full_q <= 1'b0;
            end
        end

        assign full[g] = full_q;
        assign word[g] = mem[rd_addr];
    end

    assign rd_data = rd_sel ? word[1] : word[0];
endmodule

// File: rtl/pxb_ctrl.sv
module pxb_ctrl
    import pxb_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          dir_read,
    input  logic          host_wr,
    input  logic          host_rd,
    input  logic          card_valid,
    input  logic          card_take,
    input  logic [1:0]    full,
    output xfer_state_t   state,
    output logic          flush,
    output logic          wr_en,
    output logic          wr_sel,
    output logic [AW-1:0] wr_addr,
    output logic          set_full,
    output logic          rd_sel,
    output logic [AW-1:0] rd_addr,
    output logic          clr_full,
    output logic          fill_from_card,
    output logic          card_clk_stop,
    output logic          host_ready,
    output logic          set_ur,
    output logic          set_ov,
    output logic          xbuf_full
);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    xfer_state_t   state_q, state_d;
    logic          fsel_q, dsel_q;
    logic [AW-1:0] wptr_q, rptr_q;
    logic          rd_en;

    // next-state decode
    always_comb begin
        state_d = state_q;
        if (start) begin
            state_d = dir_read ? XB_READ : XB_WRITE;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= XB_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // bank pointers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fsel_q <= 1'b0;
            dsel_q <= 1'b0;
            wptr_q <= '0;
            rptr_q <= '0;
        end else if (start) begin
            fsel_q <= 1'b0;
            dsel_q <= 1'b0;
            wptr_q <= '0;
            rptr_q <= '0;
        end else begin
            if (wr_en) begin
                if (wptr_q == LAST) begin
                    wptr_q <= '0;
                    fsel_q <= ~fsel_q;
                end else begin
                    wptr_q <= wptr_q + 1'b1;
                end
            end
            if (rd_en) begin
                if (rptr_q == LAST) begin
                    rptr_q <= '0;
                    dsel_q <= ~dsel_q;
                end else begin
                    rptr_q <= rptr_q + 1'b1;
                end
            end
        end
    end

    // outputs per state
    always_comb begin
        wr_en          = 1'b0;
        rd_en          = 1'b0;
        fill_from_card = 1'b0;
        card_clk_stop  = 1'b0;
        host_ready     = 1'b0;
        set_ur         = 1'b0;
        set_ov         = 1'b0;
        xbuf_full      = 1'b0;
        unique case (state_q)
            XB_IDLE: begin
            end
            XB_READ: begin
                fill_from_card = 1'b1;
                card_clk_stop  = full[fsel_q];
                wr_en          = card_valid & ~full[fsel_q];
                rd_en          = host_rd & full[dsel_q];
                host_ready     = full[dsel_q];
                set_ov         = full[fsel_q];
                xbuf_full      = full[0];
            end
            XB_WRITE: begin
                card_clk_stop  = ~full[dsel_q];
                wr_en          = host_wr & ~full[fsel_q];
                rd_en          = card_take & full[dsel_q];
                host_ready     = ~full[fsel_q];
                set_ur         = ~full[dsel_q];
            end
            default: begin
            end
        endcase
    end

    assign state    = state_q;
    assign flush    = start;
    assign wr_sel   = fsel_q;
    assign wr_addr  = wptr_q;
    assign rd_sel   = dsel_q;
    assign rd_addr  = rptr_q;
    assign set_full = wr_en & (wptr_q == LAST);
    assign clr_full = rd_en & (rptr_q == LAST);
endmodule

// File: rtl/pxb_status.sv
module pxb_status (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       set_ur,
    input  logic       set_ov,
    input  logic       stat_wr,
    input  logic [1:0] stat_wdata,
    input  logic [1:0] irq_en,
    output logic       underrun,
    output logic       overflow,
    output logic       irq
);
    logic ur_q, ov_q;
    logic clr_ur, clr_ov;

    assign clr_ur = stat_wr & stat_wdata[0];
    assign clr_ov = stat_wr & stat_wdata[1];

    // set takes priority over clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ur_q <= 1'b0;
            ov_q <= 1'b0;
        end else begin
            ur_q <= set_ur | (ur_q & ~clr_ur);
            ov_q <= set_ov | (ov_q & ~clr_ov);
        end
    end

    assign underrun = ur_q;
    assign overflow = ov_q;
    assign irq      = |({ov_q, ur_q} & irq_en);
endmodule

// File: rtl/pingpong_xfer_buf.sv
module pingpong_xfer_buf
    import pxb_pkg::*;
#(
    parameter int DW    = 32,
    parameter int DEPTH = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          dir_read,
    input  logic          host_wr,
    input  logic [DW-1:0] host_wdata,
    input  logic          host_rd,
    output logic [DW-1:0] host_rdata,
    output logic          host_ready,
    input  logic          card_valid,
    input  logic [DW-1:0] card_wdata,
    input  logic          card_take,
    output logic [DW-1:0] card_rdata,
    output logic          card_clk_stop,
    input  logic          stat_wr,
    input  logic [1:0]    stat_wdata,
    input  logic [1:0]    irq_en,
    output logic          underrun,
    output logic          overflow,
    output logic          xbuf_full,
    output logic          irq
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    xfer_state_t   state;
    logic          flush, wr_en, wr_sel, set_full, rd_sel, clr_full;
    logic          fill_from_card, set_ur, set_ov;
    logic [AW-1:0] wr_addr, rd_addr;
    logic [DW-1:0] wr_data, rd_data;
    logic [1:0]    buf_full;
    logic          rd_mode, wr_mode;

    assign wr_data = fill_from_card ? card_wdata : host_wdata;
    assign rd_mode = (state == XB_READ);
    assign wr_mode = (state == XB_WRITE);

    pxb_ctrl #(.DEPTH(DEPTH), .AW(AW)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .dir_read(dir_read),
        .host_wr(host_wr), .host_rd(host_rd),
        .card_valid(card_valid), .card_take(card_take),
        .full(buf_full), .state(state), .flush(flush),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_addr(wr_addr), .set_full(set_full),
        .rd_sel(rd_sel), .rd_addr(rd_addr), .clr_full(clr_full),
        .fill_from_card(fill_from_card), .card_clk_stop(card_clk_stop),
        .host_ready(host_ready), .set_ur(set_ur), .set_ov(set_ov),
        .xbuf_full(xbuf_full)
    );

    pxb_store #(.DW(DW), .DEPTH(DEPTH), .AW(AW)) u_store (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_addr(wr_addr), .wr_data(wr_data),
        .set_full(set_full), .rd_sel(rd_sel), .rd_addr(rd_addr),
        .clr_full(clr_full), .rd_data(rd_data), .full(buf_full)
    );

    pxb_status u_status (
        .clk(clk), .rst_n(rst_n), .set_ur(set_ur), .set_ov(set_ov),
        .stat_wr(stat_wr), .stat_wdata(stat_wdata), .irq_en(irq_en),
        .underrun(underrun), .overflow(overflow), .irq(irq)
    );

    assign host_rdata = rd_data;
    assign card_rdata = rd_data;
endmodule

// File: rtl/pingpong_xfer_chk.sv
module pingpong_xfer_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       start,
    input logic       card_clk_stop,
    input logic       underrun,
    input logic       overflow,
    input logic       irq,
    input logic [1:0] irq_en,
    input logic       stat_wr,
    input logic [1:0] stat_wdata,
    input logic       rd_mode,
    input logic       wr_mode,
    input logic [1:0] buf_full
);
    a_r1_idle_no_stop: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_mode && !wr_mode) |-> !card_clk_stop);

    a_r3_read_stop: assert property (@(posedge clk) disable iff (!rst_n)
        rd_mode |-> (card_clk_stop == (&buf_full)));

    a_r5_write_stop: assert property (@(posedge clk) disable iff (!rst_n)
        wr_mode |-> (card_clk_stop == ~(|buf_full)));

    a_r6_ov_set: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_mode && (&buf_full)) |=> overflow);

    a_r6_ur_set: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_mode && !(|buf_full)) |=> underrun);

    a_r8_irq_masked: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_en == 2'b00) |-> !irq);

    a_r9_ov_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_wr && stat_wdata[1] && !(rd_mode && (&buf_full))) |=> !overflow);

    a_r11_start_flush: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (buf_full == 2'b00));
endmodule

bind pingpong_xfer_buf pingpong_xfer_chk u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .card_clk_stop(card_clk_stop),
    .underrun(underrun), .overflow(overflow), .irq(irq), .irq_en(irq_en),
    .stat_wr(stat_wr), .stat_wdata(stat_wdata), .rd_mode(rd_mode),
    .wr_mode(wr_mode), .buf_full(buf_full)
);

// File: tb/pingpong_xfer_buf_test.sv
module pingpong_xfer_buf_test;
    localparam int DW    = 32;
    localparam int DEPTH = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 0, dir_read = 0, host_wr = 0, host_rd = 0;
    logic          card_valid = 0, card_take = 0, stat_wr = 0;
    logic [DW-1:0] host_wdata = '0, card_wdata = '0;
    logic [1:0]    stat_wdata = '0, irq_en = '0;
    logic [DW-1:0] host_rdata, card_rdata;
    logic          host_ready, card_clk_stop, underrun, overflow, xbuf_full, irq;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #10 clk = ~clk;

    pingpong_xfer_buf #(.DW(DW), .DEPTH(DEPTH)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .dir_read(dir_read),
        .host_wr(host_wr), .host_wdata(host_wdata), .host_rd(host_rd),
        .host_rdata(host_rdata), .host_ready(host_ready),
        .card_valid(card_valid), .card_wdata(card_wdata), .card_take(card_take),
        .card_rdata(card_rdata), .card_clk_stop(card_clk_stop),
        .stat_wr(stat_wr), .stat_wdata(stat_wdata), .irq_en(irq_en),
        .underrun(underrun), .overflow(overflow), .xbuf_full(xbuf_full), .irq(irq)
    );

    // [14]start [13]dir [12]host_wr [11]host_rd [10]card_valid [9]card_take
    // [8]stat_wr [7:6]stat_wdata | expected [5]stop [4]xfull [3]ready [2]ov [1]ur [0]irq
    localparam int NV = 18;
    localparam logic [14:0] VEC [NV] = '{
        15'b110000000_000000,  // start read
        15'b010010000_000000,  // X word 0
        15'b010010000_011000,  // X complete (R7)
        15'b010010000_011000,  // Y word 0
        15'b010010000_111000,  // both full -> stop (R3)
        15'b010010000_111100,  // discarded word, overflow (R4, R6)
        15'b010100000_111100,  // host reads X word 0
        15'b010100000_001100,  // X drained -> stop drops (R3, R7)
        15'b010000110_001000,  // clear overflow (R9)
        15'b100000000_101000,  // start write, nothing full (R5)
        15'b001000000_101011,  // underrun set, irq enabled (R6, R8)
        15'b001000000_001011,  // X complete -> card runs
        15'b000001000_001011,  // card takes X word 0
        15'b000001000_101011,  // X drained -> stop again
        15'b000000101_101011,  // clear and set together (R10)
        15'b001001000_101011,  // take while stopped ignored (R5)
        15'b001000000_001011,  // Y complete
        15'b000000101_001000   // clear underrun (R9)
    };

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle_inputs();
        start = 0; host_wr = 0; host_rd = 0; card_valid = 0; card_take = 0;
        stat_wr = 0; stat_wdata = 2'b00;
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    initial begin
        #(20 * 100000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        step();
        chk("R1 stop", card_clk_stop, 0);
        chk("R1 ready", host_ready, 0);
        chk("R1 underrun", underrun, 0);
        chk("R1 overflow", overflow, 0);
        chk("R1 irq", irq, 0);
        chk("R1 xfull", xbuf_full, 0);
        rst_n = 1'b1;
        step();
        chk("R1 idle stop", card_clk_stop, 0);

        // vector table
        irq_en = 2'b01;
        for (int i = 0; i < NV; i++) begin
            start      = VEC[i][14];
            dir_read   = VEC[i][13];
            host_wr    = VEC[i][12];
            host_rd    = VEC[i][11];
            card_valid = VEC[i][10];
            card_take  = VEC[i][9];
            stat_wr    = VEC[i][8];
            stat_wdata = VEC[i][7:6];
            host_wdata = 32'h100 + i;
            card_wdata = 32'h200 + i;
            step();
            chk($sformatf("R3/R5 stop v%0d", i), card_clk_stop, VEC[i][5]);
            chk($sformatf("R7 xfull v%0d", i), xbuf_full, VEC[i][4]);
            chk($sformatf("R12 ready v%0d", i), host_ready, VEC[i][3]);
            chk($sformatf("R6 overflow v%0d", i), overflow, VEC[i][2]);
            chk($sformatf("R6/R10 underrun v%0d", i), underrun, VEC[i][1]);
            chk($sformatf("R8 irq v%0d", i), irq, VEC[i][0]);
        end
        idle_inputs();

        // R2, R4: read order and discard
        start = 1; dir_read = 1; step();
        start = 0;
        for (int i = 0; i < 2 * DEPTH; i++) begin
            card_valid = 1; card_wdata = 32'hA0 + i; step();
        end
        card_wdata = 32'hEE; step();
        card_valid = 0;
        for (int i = 0; i < 2 * DEPTH; i++) begin
            chk("R12 read ready", host_ready, 1);
            chk("R2 read order", host_rdata, 32'hA0 + i);
            host_rd = 1; step();
            host_rd = 0;
        end
        chk("R4 discarded word absent", host_ready, 0);

        // R2, R5: write order and ignored take
        start = 1; dir_read = 0; step();
        start = 0;
        card_take = 1; step();
        card_take = 0;
        chk("R5 stopped", card_clk_stop, 1);
        for (int i = 0; i < 2 * DEPTH; i++) begin
            host_wr = 1; host_wdata = 32'hB0 + i; step();
        end
        host_wr = 0;
        chk("R12 write ready full", host_ready, 0);
        for (int i = 0; i < 2 * DEPTH; i++) begin
            chk("R5 running", card_clk_stop, 0);
            chk("R2 write order", card_rdata, 32'hB0 + i);
            card_take = 1; step();
            card_take = 0;
        end
        chk("R5 stop when empty", card_clk_stop, 1);

        // R8, R9, R11
        start = 1; dir_read = 1; step();
        start = 0; stat_wr = 1; stat_wdata = 2'b11; step();
        stat_wr = 0; stat_wdata = 2'b00;
        chk("R9 both cleared ur", underrun, 0);
        chk("R9 both cleared ov", overflow, 0);
        for (int i = 0; i < 2 * DEPTH; i++) begin
            card_valid = 1; card_wdata = 32'hC0 + i; step();
        end
        card_valid = 0; step();
        irq_en = 2'b10; #1;
        chk("R8 overflow irq", irq, 1);
        irq_en = 2'b01; #1;
        chk("R8 overflow masked", irq, 0);
        step();
        stat_wr = 1; stat_wdata = 2'b00; step();
        stat_wr = 0;
        chk("R9 zero write no effect", overflow, 1);
        start = 1; dir_read = 1; step();
        start = 0;
        chk("R11 banks empty ready", host_ready, 0);
        chk("R11 banks empty stop", card_clk_stop, 0);
        chk("R11 banks empty xfull", xbuf_full, 0);
        card_valid = 1; card_wdata = 32'hD0; step();
        card_valid = 0;
        chk("R11 pointer restart", host_ready, 0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule